// File: doc/BRIEF.md
# Configurable Programmable I/O Cell

This block is one I/O cell of a programmable-logic fabric. Static configuration inputs set how it behaves. The output path carries a value from the logic array to the pad. The input path carries the pad level back into the routing. A single flip-flop sits between the two paths, and either one of them can be registered through it.

The flip-flop's clock is one of four global clocks, taken through an optional inversion. Its clock enable and its asynchronous clear each come from their own selector. The pad's output enable comes from an eight-way selector and can be delayed through a second flip-flop.

The pad is modelled as three split signals: a drive value, an enable, and an external driver. A keeper holds the last driven level whenever nobody drives the pad. A slew configuration bit is passed straight through to the buffer.

Top module: `prog_io_cell`

## Requirements
- R1: The 3-bit `cfgOeSel` code picks the output enable. Codes 0 to 3 select `gctl[0..3]`. Codes 4 and 5 select `chanCtl[0]` and `chanCtl[1]`. Code 6 means always enabled and code 7 means always disabled. This holds while `cfgRegOe` is 0.
- R2: With `cfgRegOut`=0, `padOut` equals `coreOut` combinationally. With `cfgRegIn`=0, `coreIn` equals `padLevel` combinationally.
- R3: With `cfgRegOut`=1, `padOut` takes `coreOut` at the active edge of the global clock numbered `cfgClkSel`. Edges on the other global clocks have no effect.
- R4: With `cfgClkInv`=1, the register captures on the falling edge of the selected clock and ignores its rising edge.
- R5: With `cfgRegIn`=1 and `cfgRegOut`=0, `coreIn` shows the `padLevel` captured at the last active edge.
- R6: When both `cfgRegIn` and `cfgRegOut` are 1, `configError` is 1. In that case only the output path is registered, and `coreIn` follows `padLevel` combinationally.
- R7: `cfgEnSel` uses the same coding as R1 to pick the register clock enable. While the selected enable is 0, the register holds its value across active edges.
- R8: `cfgRstSel` codes 0 to 3 pick `gctl[code]` as an asynchronous, active-high clear that sets the register to 0. Codes 4 to 7 select no clear.
- R9: With `cfgRegOe`=1, `padOe` shows the enable selected by R1 as it was captured at the last active edge of the register clock.
- R10: `padLevel` is `padOut` when `padOe`=1. Otherwise it is `padExtVal` when `padExtEn`=1. Otherwise it is the last value driven onto the pad by either side.
- R11: `slewSlow` follows `cfgSlewSlow`. A value of 0 selects the fast edge, and the cleared configuration gives fast.
- R12: While `porN`=0, both flip-flops and the keeper are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 4 | Global clocks |
| gctl | input | 4 | Global control signals |
| chanCtl | input | 2 | Channel output-control signals |
| porN | input | 1 | Power-on clear, active low |
| cfgOeSel | input | 3 | Output-enable source code |
| cfgEnSel | input | 3 | Register-enable source code |
| cfgRstSel | input | 3 | Register-clear source code |
| cfgClkSel | input | 2 | Global clock index |
| cfgClkInv | input | 1 | Clock inversion |
| cfgRegOut | input | 1 | Register the output path |
| cfgRegIn | input | 1 | Register the input path |
| cfgRegOe | input | 1 | Register the output enable |
| cfgSlewSlow | input | 1 | Slow slew select |
| coreOut | input | 1 | Value from the logic array |
| padExtEn | input | 1 | External driver active on the pad |
| padExtVal | input | 1 | External driver value |
| padOut | output | 1 | Value driven to the pad |
| padOe | output | 1 | Pad output enable |
| padLevel | output | 1 | Resolved pad level |
| coreIn | output | 1 | Value returned to the routing |
| slewSlow | output | 1 | Slew setting to the buffer |
| configError | output | 1 | Both paths asked for the register |

## Verification
The combinational results (R1, R2, R6, R8 clear, R10, R11, R12) settle with no clock edge, so the bench checks them one nanosecond after changing an input. The registered results (R3, R4, R5, R7, R9) change exactly one active edge of the selected clock after their input changes. For these, the bench first checks that the old value persists, then checks the new one two nanoseconds after that edge. That edge is the rising edge, or the falling edge when R4 is under test. Configuration changes are made only while the selected clock is low, or, for the inversion bit, at the level where the change causes no rising edge. This keeps stray captures out of the expected timing.

// File: rtl/pio_pkg.sv
package pio_pkg;
  // Strobes passed from the selector logic to the datapath
  typedef struct packed {
    logic regEn;     // clock enable of the shared register
    logic regClr;    // asynchronous clear from the reset selector
    logic useRegOut; // output path goes through the register
    logic useRegIn;  // input path goes through the register
    logic oeRaw;     // selected output enable before optional delay
    logic cfgErr;    // both paths requested the register
  } pioStrobes_t;
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int NUM_GCLK = 4,
  parameter int NUM_GCTL = 4,
  parameter int NUM_CHAN = 2,
  localparam int SRC_N   = NUM_GCTL + NUM_CHAN + 2,
  localparam int SEL_W   = $clog2(SRC_N),
  localparam int CLK_W   = $clog2(NUM_GCLK)
) (
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic [NUM_GCTL-1:0] gctl,
  input  logic [NUM_CHAN-1:0] chanCtl,
  input  logic [SEL_W-1:0]    cfgOeSel,
  input  logic [SEL_W-1:0]    cfgEnSel,
  input  logic [SEL_W-1:0]    cfgRstSel,
  input  logic [CLK_W-1:0]    cfgClkSel,
  input  logic                cfgClkInv,
  input  logic                cfgRegOut,
  input  logic                cfgRegIn,
  output logic                regClk,
  output pioStrobes_t         strb
);
  // Source vector: globals, then channels, then constant 1, then constant 0
  logic [SRC_N-1:0] srcVec;
  assign srcVec = {1'b0, 1'b1, chanCtl, gctl};

  function automatic logic pickSrc(input logic [SRC_N-1:0] v, input logic [SEL_W-1:0] s);
    logic r;
    r = 1'b0;
    for (int i = 0; i < SRC_N; i++)
      if (s == SEL_W'(i)) r = v[i];
    return r;
  endfunction

  // Clock selection with polarity stage
  logic [NUM_GCLK-1:0] clkHit;
  genvar g;
  generate
    for (g = 0; g < NUM_GCLK; g++) begin : gen_clk_sel
      assign clkHit[g] = (cfgClkSel == CLK_W'(g)) & gclk[g];
    end
  endgenerate
  assign regClk = (|clkHit) ^ cfgClkInv;

  // Reset selection: only the global controls may clear
  logic rstPick;
  always_comb begin
    rstPick = 1'b0;
    for (int i = 0; i < NUM_GCTL; i++)
      if (cfgRstSel == SEL_W'(i)) rstPick = gctl[i];
  end

  always_comb begin
    strb.oeRaw     = pickSrc(srcVec, cfgOeSel);
    strb.regEn     = pickSrc(srcVec, cfgEnSel);
    strb.regClr    = rstPick;
    strb.cfgErr    = cfgRegOut & cfgRegIn;
    strb.useRegOut = cfgRegOut;
    strb.useRegIn  = cfgRegIn & ~cfgRegOut;
  end
endmodule

// File: rtl/pio_dpath.sv
module pio_dpath
  import pio_pkg::*;
(
  input  logic        regClk,
  input  logic        porN,
  input  pioStrobes_t strb,
  input  logic        cfgRegOe,
  input  logic        coreOut,
  input  logic        padExtEn,
  input  logic        padExtVal,
  output logic        padOut,
  output logic        padOe,
  output logic        padLevel,
  output logic        coreIn
);
  logic asyncClr;
  logic sharedQ;
  logic oeQ;
  logic keepVal;
  logic regD;
  logic drivenVal;
  logic driven;

  assign asyncClr = ~porN | strb.regClr;
  assign regD     = strb.useRegOut ? coreOut : padLevel;

  always_ff @(posedge regClk or posedge asyncClr) begin
    if (asyncClr)        sharedQ <= 1'b0;
    else if (strb.regEn) sharedQ <= regD;
  end

  always_ff @(posedge regClk or posedge asyncClr) begin
    if (asyncClr) oeQ <= 1'b0;
    else          oeQ <= strb.oeRaw;
  end

  assign padOut    = strb.useRegOut ? sharedQ : coreOut;
  assign padOe     = cfgRegOe ? oeQ : strb.oeRaw;
  assign driven    = padOe | padExtEn;
  assign drivenVal = padOe ? padOut : padExtVal;

  // Bus-hold keeper: transparent while the pad is driven
  always_latch begin
    if (!porN)       keepVal <= 1'b0;
    else if (driven) keepVal <= drivenVal;
  end

  assign padLevel = driven ? drivenVal : keepVal;
  assign coreIn   = strb.useRegIn ? sharedQ : padLevel;
endmodule

// File: rtl/prog_io_cell.sv
module prog_io_cell
  import pio_pkg::*;
#(
  parameter int NUM_GCLK = 4,
  parameter int NUM_GCTL = 4,
  parameter int NUM_CHAN = 2
) (
  input  logic [NUM_GCLK-1:0]                       gclk,
  input  logic [NUM_GCTL-1:0]                       gctl,
  input  logic [NUM_CHAN-1:0]                       chanCtl,
  input  logic                                      porN,
  input  logic [$clog2(NUM_GCTL+NUM_CHAN+2)-1:0]    cfgOeSel,
  input  logic [$clog2(NUM_GCTL+NUM_CHAN+2)-1:0]    cfgEnSel,
  input  logic [$clog2(NUM_GCTL+NUM_CHAN+2)-1:0]    cfgRstSel,
  input  logic [$clog2(NUM_GCLK)-1:0]               cfgClkSel,
  input  logic                                      cfgClkInv,
  input  logic                                      cfgRegOut,
  input  logic                                      cfgRegIn,
  input  logic                                      cfgRegOe,
  input  logic                                      cfgSlewSlow,
  input  logic                                      coreOut,
  input  logic                                      padExtEn,
  input  logic                                      padExtVal,
  output logic                                      padOut,
  output logic                                      padOe,
  output logic                                      padLevel,
  output logic                                      coreIn,
  output logic                                      slewSlow,
  output logic                                      configError
);
  logic        regClk;
  pioStrobes_t strb;

  pio_ctrl #(.NUM_GCLK(NUM_GCLK), .NUM_GCTL(NUM_GCTL), .NUM_CHAN(NUM_CHAN)) u_ctrl (
    .gclk(gclk), .gctl(gctl), .chanCtl(chanCtl),
    .cfgOeSel(cfgOeSel), .cfgEnSel(cfgEnSel), .cfgRstSel(cfgRstSel),
    .cfgClkSel(cfgClkSel), .cfgClkInv(cfgClkInv),
    .cfgRegOut(cfgRegOut), .cfgRegIn(cfgRegIn),
    .regClk(regClk), .strb(strb)
  );

  pio_dpath u_dpath (
    .regClk(regClk), .porN(porN), .strb(strb), .cfgRegOe(cfgRegOe),
    .coreOut(coreOut), .padExtEn(padExtEn), .padExtVal(padExtVal),
    .padOut(padOut), .padOe(padOe), .padLevel(padLevel), .coreIn(coreIn)
  );

  assign slewSlow    = cfgSlewSlow;
  assign configError = strb.cfgErr;
endmodule

// File: rtl/prog_io_cell_chk.sv
module prog_io_cell_chk #(
  parameter int NUM_GCTL = 4,
  parameter int NUM_CHAN = 2,
  parameter int SEL_W    = 3
) (
  input logic             sampleClk,
  input logic             porN,
  input logic [SEL_W-1:0] cfgOeSel,
  input logic             cfgRegOe,
  input logic             cfgRegOut,
  input logic             coreOut,
  input logic             padOut,
  input logic             padOe,
  input logic             padExtEn,
  input logic             padLevel,
  input logic             coreIn,
  input logic             configError
);
  localparam logic [SEL_W-1:0] ON_CODE  = SEL_W'(NUM_GCTL + NUM_CHAN);
  localparam logic [SEL_W-1:0] OFF_CODE = SEL_W'(NUM_GCTL + NUM_CHAN + 1);

  // R1
  oe_always_on_chk: assert property (@(posedge sampleClk) disable iff (!porN)
    (cfgOeSel == ON_CODE && !cfgRegOe) |-> padOe);

  // R1
  oe_always_off_chk: assert property (@(posedge sampleClk) disable iff (!porN)
    (cfgOeSel == OFF_CODE && !cfgRegOe) |-> !padOe);

  // R2
  comb_out_path_chk: assert property (@(posedge sampleClk) disable iff (!porN)
    !cfgRegOut |-> (padOut == coreOut));

  // R6
  err_input_comb_chk: assert property (@(posedge sampleClk) disable iff (!porN)
    configError |-> (coreIn == padLevel));

  // R10
  keeper_hold_chk: assert property (@(posedge sampleClk) disable iff (!porN)
    ($past(!padOe && !padExtEn) && !padOe && !padExtEn) |-> $stable(padLevel));
endmodule

bind prog_io_cell prog_io_cell_chk #(
  .NUM_GCTL(NUM_GCTL), .NUM_CHAN(NUM_CHAN), .SEL_W($clog2(NUM_GCTL+NUM_CHAN+2))
) u_chk (
  .sampleClk(gclk[0]), .porN(porN), .cfgOeSel(cfgOeSel), .cfgRegOe(cfgRegOe),
  .cfgRegOut(cfgRegOut), .coreOut(coreOut), .padOut(padOut), .padOe(padOe),
  .padExtEn(padExtEn), .padLevel(padLevel), .coreIn(coreIn),
  .configError(configError)
);

// File: tb/prog_io_cell_bench.sv
module prog_io_cell_bench;
  logic       clk = 1'b0;
  logic [3:1] gclkHi;
  logic [3:0] gclk;
  logic [3:0] gctl;
  logic [1:0] chanCtl;
  logic       porN;
  logic [2:0] cfgOeSel, cfgEnSel, cfgRstSel;
  logic [1:0] cfgClkSel;
  logic       cfgClkInv, cfgRegOut, cfgRegIn, cfgRegOe, cfgSlewSlow;
  logic       coreOut, padExtEn, padExtVal;
  logic       padOut, padOe, padLevel, coreIn, slewSlow, configError;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;
  assign gclk = {gclkHi, clk};

  prog_io_cell u_prog_io_cell (
    .gclk(gclk), .gctl(gctl), .chanCtl(chanCtl), .porN(porN),
    .cfgOeSel(cfgOeSel), .cfgEnSel(cfgEnSel), .cfgRstSel(cfgRstSel),
    .cfgClkSel(cfgClkSel), .cfgClkInv(cfgClkInv), .cfgRegOut(cfgRegOut),
    .cfgRegIn(cfgRegIn), .cfgRegOe(cfgRegOe), .cfgSlewSlow(cfgSlewSlow),
    .coreOut(coreOut), .padExtEn(padExtEn), .padExtVal(padExtVal),
    .padOut(padOut), .padOe(padOe), .padLevel(padLevel), .coreIn(coreIn),
    .slewSlow(slewSlow), .configError(configError)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic afterRise(); @(posedge clk); #2; endtask
  task automatic atLow();     @(negedge clk); #2; endtask

  task automatic tReset();
    porN = 1'b0; gctl = '0; chanCtl = '0; gclkHi = '0;
    cfgOeSel = 3'd7; cfgEnSel = 3'd6; cfgRstSel = 3'd4; cfgClkSel = '0;
    cfgClkInv = 0; cfgRegOut = 0; cfgRegIn = 0; cfgRegOe = 0; cfgSlewSlow = 0;
    coreOut = 0; padExtEn = 0; padExtVal = 0;
    #25;
    chk("R12 coreIn in reset", coreIn, 1'b0);
    chk("R12 padLevel in reset", padLevel, 1'b0);
    chk("R11 slew fast after clear", slewSlow, 1'b0);
    chk("R6 no error by default", configError, 1'b0);
    porN = 1'b1;
  endtask

  task automatic tOeSelect();
    for (int code = 0; code < 8; code++) begin
      cfgOeSel = 3'(code);
      if (code < 4) begin
        gctl = 4'(1 << code); chanCtl = 2'b00; #1;
        chk("R1 oe global on", padOe, 1'b1);
        gctl = ~4'(1 << code); chanCtl = 2'b11; #1;
        chk("R1 oe global off", padOe, 1'b0);
      end else if (code < 6) begin
        chanCtl = 2'(1 << (code - 4)); gctl = '0; #1;
        chk("R1 oe channel on", padOe, 1'b1);
        chanCtl = ~2'(1 << (code - 4)); gctl = 4'hF; #1;
        chk("R1 oe channel off", padOe, 1'b0);
      end else if (code == 6) begin
        gctl = '0; chanCtl = '0; #1;
        chk("R1 oe always on", padOe, 1'b1);
      end else begin
        gctl = 4'hF; chanCtl = 2'b11; #1;
        chk("R1 oe always off", padOe, 1'b0);
      end
    end
    gctl = '0; chanCtl = '0;
  endtask

  task automatic tComb();
    cfgOeSel = 3'd6; coreOut = 1; #1;
    chk("R2 padOut comb high", padOut, 1'b1);
    chk("R2 coreIn comb high", coreIn, 1'b1);
    coreOut = 0; #1;
    chk("R2 padOut comb low", padOut, 1'b0);
    chk("R2 coreIn comb low", coreIn, 1'b0);
    cfgOeSel = 3'd7; padExtEn = 1; padExtVal = 1; #1;
    chk("R2 coreIn from external", coreIn, 1'b1);
  endtask

  task automatic tRegOut();
    atLow();
    padExtEn = 0; cfgOeSel = 3'd6; cfgRegOut = 1; coreOut = 0;
    afterRise();
    chk("R3 reg out start", padOut, 1'b0);
    coreOut = 1; #1;
    chk("R3 reg out before edge", padOut, 1'b0);
    afterRise();
    chk("R3 reg out after edge", padOut, 1'b1);
    atLow();
    cfgClkSel = 2'd1; coreOut = 0;
    afterRise();
    chk("R3 unselected clock ignored", padOut, 1'b1);
    gclkHi[1] = 1'b1; #2;
    chk("R3 selected clock captures", padOut, 1'b0);
    gclkHi[1] = 1'b0;
    atLow();
    cfgClkSel = 2'd0;
  endtask

  task automatic tPolarity();
    @(posedge clk); #5;
    cfgClkInv = 1; coreOut = 1; #2;
    chk("R4 no capture before fall", padOut, 1'b0);
    atLow();
    chk("R4 capture on fall", padOut, 1'b1);
    coreOut = 0;
    afterRise();
    chk("R4 rise ignored", padOut, 1'b1);
    atLow();
    chk("R4 second fall captures", padOut, 1'b0);
    cfgClkInv = 0;
  endtask

  task automatic tRegIn();
    atLow();
    cfgRegOut = 0; cfgRegIn = 1; cfgOeSel = 3'd7; padExtEn = 1; padExtVal = 1; #1;
    chk("R5 reg in before edge", coreIn, 1'b0);
    afterRise();
    chk("R5 reg in after edge", coreIn, 1'b1);
    padExtVal = 0; #1;
    chk("R5 reg in holds between edges", coreIn, 1'b1);
  endtask

  task automatic tConfigErr();
    atLow();
    cfgRegOut = 1; #1;
    chk("R6 error flag raised", configError, 1'b1);
    padExtVal = 1; #1;
    chk("R6 input path comb", coreIn, 1'b1);
    coreOut = 0; #1;
    chk("R6 output still registered", padOut, 1'b1);
    afterRise();
    chk("R6 output captured", padOut, 1'b0);
    cfgRegIn = 0; #1;
    chk("R6 error flag cleared", configError, 1'b0);
  endtask

  task automatic tEnable();
    atLow();
    cfgEnSel = 3'd0; gctl = '0; coreOut = 1;
    afterRise();
    chk("R7 disabled holds", padOut, 1'b0);
    gctl[0] = 1'b1;
    afterRise();
    chk("R7 enabled captures", padOut, 1'b1);
    gctl = '0; cfgEnSel = 3'd6;
  endtask

  task automatic tReset2();
    atLow();
    cfgRstSel = 3'd2; gctl[2] = 1'b1; #1;
    chk("R8 async clear", padOut, 1'b0);
    gctl[2] = 1'b0; coreOut = 1;
    afterRise();
    chk("R8 recapture after clear", padOut, 1'b1);
    cfgRstSel = 3'd5; gctl = 4'hF; #1;
    chk("R8 no clear source", padOut, 1'b1);
    gctl = '0; cfgRstSel = 3'd4;
  endtask

  task automatic tRegOe();
    atLow();
    cfgRegOe = 1; cfgOeSel = 3'd4; chanCtl = 2'b00;
    afterRise();
    chk("R9 delayed oe low", padOe, 1'b0);
    chanCtl[0] = 1'b1; #1;
    chk("R9 oe waits for edge", padOe, 1'b0);
    afterRise();
    chk("R9 oe after edge", padOe, 1'b1);
    chanCtl = 2'b00; #1;
    chk("R9 oe holds until edge", padOe, 1'b1);
    afterRise();
    chk("R9 oe falls after edge", padOe, 1'b0);
    cfgRegOe = 0;
  endtask

  task automatic tBusHold();
    atLow();
    cfgRegOut = 0; padExtEn = 0; cfgOeSel = 3'd6; coreOut = 1;
    afterRise();
    chk("R10 driven by cell", padLevel, 1'b1);
    cfgOeSel = 3'd7;
    afterRise();
    chk("R10 keeper holds high", padLevel, 1'b1);
    coreOut = 0;
    afterRise();
    chk("R10 coreOut ignored when off", padLevel, 1'b1);
    padExtEn = 1; padExtVal = 0;
    afterRise();
    chk("R10 external drives", padLevel, 1'b0);
    padExtEn = 0;
    afterRise();
    chk("R10 keeper holds low", padLevel, 1'b0);
    padExtVal = 1;
    afterRise();
    chk("R10 undriven value ignored", padLevel, 1'b0);
  endtask

  task automatic tSlew();
    cfgSlewSlow = 1; #1;
    chk("R11 slow slew", slewSlow, 1'b1);
    cfgSlewSlow = 0; #1;
    chk("R11 fast slew", slewSlow, 1'b0);
  endtask

  task automatic tPowerOn();
    atLow();
    cfgRegOut = 1; coreOut = 1; cfgOeSel = 3'd6;
    afterRise();
    chk("R12 register loaded", padOut, 1'b1);
    cfgOeSel = 3'd7;
    afterRise();
    chk("R12 keeper loaded", padLevel, 1'b1);
    porN = 1'b0; #1;
    chk("R12 register cleared", padOut, 1'b0);
    chk("R12 keeper cleared", padLevel, 1'b0);
    atLow();
    porN = 1'b1;
  endtask

  initial begin
    tReset();
    tOeSelect();
    tComb();
    tRegOut();
    tPolarity();
    tRegIn();
    tConfigErr();
    tEnable();
    tReset2();
    tRegOe();
    tBusHold();
    tSlew();
    tPowerOn();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule